// File: doc/BRIEF.md
# Ring-Written Parallel-Search Index Store

This block keeps a small table of words that is written in order, like a ring buffer. It can also be searched all at once, like a content-addressable memory. Each write places the input word in the slot named by a write pointer. The pointer then moves to the next slot and wraps at the end, so the oldest entry is the one overwritten. A read compares the same input word against every slot in one cycle. One clock edge later it returns the number of a slot that holds that word, together with a flag that says whether a match was found.

The table may hold the same value in more than one slot. The search then reports the highest-numbered slot that matches. Each slot has a fill bit that reset clears, so a slot that has never been written cannot produce a match. A search in the same cycle as a write sees the table as it was before that write.

Top module: `cam_ring_lookup`

## Requirements
- R1: An asynchronous active-low reset forces `idx_vld_o` low and `idx_o` to zero at once. It also clears the fill bits, so after reset no search matches, including a search for a word of all zeros.
- R2: After reset the write pointer is at slot 0. Each cycle with `wr_en_i` high stores `word_i` in the slot the pointer names and advances the pointer by one. After slot 2^DEPTH_BITS-1 the pointer returns to slot 0 and overwrites the oldest entry, whose old value can then no longer be found.
- R3: A cycle with `rd_en_i` high and a matching written slot gives `idx_vld_o` = 1 and `idx_o` = that slot's number after the next rising edge.
- R4: A search that matches no written slot gives `idx_vld_o` = 0 and `idx_o` = 0 after the next rising edge.
- R5: A cycle with `rd_en_i` low gives `idx_vld_o` = 0 and `idx_o` = 0 after the next rising edge, even when `word_i` matches a stored entry.
- R6: When several written slots hold the searched word, `idx_o` is the highest-numbered one.
- R7: When `rd_en_i` and `wr_en_i` are both high in one cycle, the search uses the contents from before that cycle's write. A word that is being written for the first time is therefore not found in that cycle, but it is found by a later search.
- R8: A slot that has not been written since reset never matches, whatever its contents.
- R9: A cycle with `wr_en_i` low changes neither the table nor the write pointer. The next write goes to the slot the pointer already named.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | WORD_W | Word to store or to search for |
| rd_en_i | input | 1 | Search request |
| wr_en_i | input | 1 | Write request at the ring pointer |
| idx_o | output | DEPTH_BITS | Registered number of the matching slot |
| idx_vld_o | output | 1 | Registered match flag |

## Verification
The bench builds the block with WORD_W = 8 and DEPTH_BITS = 3, which gives eight slots. With this size a few writes are enough to wrap the pointer, overwrite slot 0 and fill every slot with one value. The narrow word makes it simple to choose values that are present, absent or duplicated. The wrap, the highest-index choice across all eight slots, and the read during a write are each reached within a few dozen cycles.

// File: rtl/cam_ring_store.sv
module cam_ring_store #(
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned DEPTH_BITS = 6,
  localparam int unsigned DEPTH     = 1 << DEPTH_BITS
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [WORD_W-1:0]              word_i,
  output logic [DEPTH-1:0][WORD_W-1:0]   data_o,
  output logic [DEPTH-1:0]               fill_o
);

  logic [DEPTH_BITS-1:0] wr_ptr_q;

  // power-of-two depth: pointer wraps by overflow
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      wr_ptr_q <= '0;
    else if (wr_en_i) wr_ptr_q <= wr_ptr_q + 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic sel_w;
    assign sel_w = wr_en_i && (wr_ptr_q == DEPTH_BITS'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        fill_o[g] <= 1'b0;
        data_o[g] <= '0;
      end else if (sel_w) begin
        fill_o[g] <= 1'b1;
        data_o[g] <= word_i;
      end
    end
  end

  assert_ptr_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> wr_ptr_q == DEPTH_BITS'($past(wr_ptr_q) + 1'b1));

  assert_ptr_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(wr_ptr_q));

  assert_fill_mono_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(fill_o));

endmodule

// File: rtl/cam_ring_match.sv
module cam_ring_match #(
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned DEPTH_BITS = 6,
  localparam int unsigned DEPTH     = 1 << DEPTH_BITS
) (
  input  logic [WORD_W-1:0]             word_i,
  input  logic [DEPTH-1:0][WORD_W-1:0]  data_i,
  input  logic [DEPTH-1:0]              fill_i,
  output logic [DEPTH-1:0]              hit_o
);

  // equal when xor is all zero; unfilled slots masked
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_o[g] = fill_i[g] && ~|(data_i[g] ^ word_i);
  end

endmodule

// File: rtl/cam_ring_prio.sv
module cam_ring_prio #(
  parameter int unsigned DEPTH_BITS = 6,
  localparam int unsigned DEPTH     = 1 << DEPTH_BITS
) (
  input  logic [DEPTH-1:0]      hit_i,
  output logic [DEPTH_BITS-1:0] sel_o,
  output logic                  any_o
);

  // later iterations win: highest set bit
  always_comb begin
    sel_o = '0;
    any_o = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hit_i[i]) begin
        sel_o = DEPTH_BITS'(i);
        any_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/cam_ring_lookup.sv
module cam_ring_lookup #(
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned DEPTH_BITS = 6,
  localparam int unsigned DEPTH     = 1 << DEPTH_BITS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [WORD_W-1:0]     word_i,
  input  logic                  rd_en_i,
  input  logic                  wr_en_i,
  output logic [DEPTH_BITS-1:0] idx_o,
  output logic                  idx_vld_o
);

  logic [DEPTH-1:0][WORD_W-1:0] data_w;
  logic [DEPTH-1:0]             fill_w;
  logic [DEPTH-1:0]             hit_w;
  logic [DEPTH_BITS-1:0]        sel_w;
  logic                         any_w;
  logic                         found_w;

  cam_ring_store #(.WORD_W(WORD_W), .DEPTH_BITS(DEPTH_BITS)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .word_i  (word_i),
    .data_o  (data_w),
    .fill_o  (fill_w)
  );

  // compares pre-write contents: store updates on the same edge
  cam_ring_match #(.WORD_W(WORD_W), .DEPTH_BITS(DEPTH_BITS)) u_match (
    .word_i (word_i),
    .data_i (data_w),
    .fill_i (fill_w),
    .hit_o  (hit_w)
  );

  cam_ring_prio #(.DEPTH_BITS(DEPTH_BITS)) u_prio (
    .hit_i (hit_w),
    .sel_o (sel_w),
    .any_o (any_w)
  );

  assign found_w = rd_en_i && any_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o     <= '0;
      idx_vld_o <= 1'b0;
    end else begin
      idx_vld_o <= found_w;
      idx_o     <= found_w ? sel_w : '0;
    end
  end

  assert_idle_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !idx_vld_o && idx_o == '0);

  assert_miss_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idx_vld_o |-> idx_o == '0);

  assert_true_hit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_w |-> hit_w[sel_w] && fill_w[sel_w] && data_w[sel_w] == word_i);

  assert_highest_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_w |-> (hit_w >> sel_w) == DEPTH'(1));

endmodule

// File: tb/cam_ring_lookup_test.sv
module cam_ring_lookup_test;

  localparam int unsigned WW = 8;
  localparam int unsigned DB = 3;
  localparam int unsigned NV = 22;

  // {wr, rd, word, exp_vld, exp_idx}
  localparam logic [13:0] VEC [NV] = '{
    {1'b0, 1'b1, 8'h00, 1'b0, 3'd0},  // 0  R8 empty table
    {1'b1, 1'b0, 8'h11, 1'b0, 3'd0},  // 1  R2 slot0
    {1'b1, 1'b0, 8'h22, 1'b0, 3'd0},  // 2  slot1
    {1'b1, 1'b0, 8'h33, 1'b0, 3'd0},  // 3  slot2
    {1'b1, 1'b0, 8'h22, 1'b0, 3'd0},  // 4  slot3 duplicate
    {1'b0, 1'b1, 8'h11, 1'b1, 3'd0},  // 5  R3
    {1'b0, 1'b1, 8'h22, 1'b1, 3'd3},  // 6  R6 highest of 1,3
    {1'b0, 1'b1, 8'h44, 1'b0, 3'd0},  // 7  R4 miss
    {1'b1, 1'b1, 8'h44, 1'b0, 3'd0},  // 8  R7 pre-write miss, slot4
    {1'b0, 1'b1, 8'h44, 1'b1, 3'd4},  // 9  R7 found later
    {1'b0, 1'b1, 8'h00, 1'b0, 3'd0},  // 10 R8 slots 5..7 unwritten
    {1'b1, 1'b0, 8'h55, 1'b0, 3'd0},  // 11 slot5
    {1'b1, 1'b0, 8'h66, 1'b0, 3'd0},  // 12 slot6
    {1'b1, 1'b0, 8'h77, 1'b0, 3'd0},  // 13 slot7
    {1'b1, 1'b0, 8'h88, 1'b0, 3'd0},  // 14 R2 wrap to slot0
    {1'b0, 1'b1, 8'h11, 1'b0, 3'd0},  // 15 R2 oldest gone
    {1'b0, 1'b1, 8'h88, 1'b1, 3'd0},  // 16 R2 new value at 0
    {1'b0, 1'b0, 8'h99, 1'b0, 3'd0},  // 17 R9 no write
    {1'b0, 1'b1, 8'h99, 1'b0, 3'd0},  // 18 R9 not stored
    {1'b1, 1'b0, 8'hBB, 1'b0, 3'd0},  // 19 R9 goes to slot1
    {1'b0, 1'b1, 8'hBB, 1'b1, 3'd1},  // 20 R9 pointer held
    {1'b0, 1'b0, 8'hBB, 1'b0, 3'd0}   // 21 R5 read low
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [WW-1:0] word_i = '0;
  logic          rd_en_i = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [DB-1:0] idx_o;
  logic          idx_vld_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  cam_ring_lookup #(.WORD_W(WW), .DEPTH_BITS(DB)) uut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .word_i    (word_i),
    .rd_en_i   (rd_en_i),
    .wr_en_i   (wr_en_i),
    .idx_o     (idx_o),
    .idx_vld_o (idx_vld_o)
  );

  always #5 clk_i = ~clk_i;

  task automatic check(input string req, input logic ev, input logic [DB-1:0] ei);
    checks++;
    if (idx_vld_o !== ev || idx_o !== ei) begin
      errors++;
      $display("FAIL %s: vld=%b idx=%0d expected vld=%b idx=%0d",
               req, idx_vld_o, idx_o, ev, ei);
    end
  endtask

  // drive at negedge, apply at posedge, sample at following negedge
  task automatic cyc(input logic wr, input logic rd, input logic [WW-1:0] w);
    wr_en_i = wr;
    rd_en_i = rd;
    word_i  = w;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    check("R1 reset held", 1'b0, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][13], VEC[i][12], VEC[i][11:4]);
      checks++;
      if (idx_vld_o !== VEC[i][3] || idx_o !== VEC[i][2:0]) begin
        errors++;
        $display("FAIL table row %0d: vld=%b idx=%0d expected vld=%b idx=%0d",
                 i, idx_vld_o, idx_o, VEC[i][3], VEC[i][2:0]);
      end
    end

    // R1: asynchronous reset mid-cycle clears a valid result at once
    cyc(1'b0, 1'b1, 8'hBB);
    check("R3 before reset", 1'b1, 3'd1);
    #2 rst_ni = 1'b0;
    #1 check("R1 async clear", 1'b0, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    cyc(1'b0, 1'b1, 8'h88);
    check("R1 fill bits cleared", 1'b0, '0);
    cyc(1'b0, 1'b1, 8'h00);
    check("R8 zero word after reset", 1'b0, '0);

    // R6: same value in every slot
    for (int i = 0; i < 8; i++) cyc(1'b1, 1'b0, 8'h5A);
    cyc(1'b0, 1'b1, 8'h5A);
    check("R6 all slots equal", 1'b1, 3'd7);
    // R7: overwrite slot0 while searching old value
    cyc(1'b1, 1'b1, 8'h5A);
    check("R7 concurrent read/write", 1'b1, 3'd7);
    cyc(1'b1, 1'b1, 8'h01);
    check("R7 new word not yet visible", 1'b0, '0);
    cyc(1'b0, 1'b1, 8'h01);
    check("R2 slot1 after wrap", 1'b1, 3'd1);
    cyc(1'b0, 1'b0, 8'h01);
    check("R5 read low after hit", 1'b0, '0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule